// File: doc/BRIEF.md
# Multi-Mode Reload/Capture Timer

This block is a 16-bit down-counter with two 16-bit companion registers, A and B. Depending on the selected mode the companions hold reload values or capture the counter. The block serves one pin that it can drive or sense (pin A) and one pin that it only senses (pin B). It raises a single interrupt request from a set of pending flags, each gated by its own enable.

There are three useful modes. In the first, the counter reloads from A and B in turn and toggles pin A, so it produces a waveform with no processor help. In the second, it counts edges on pin A instead of clock ticks. In the third, it runs freely and latches its value into A or B when an edge arrives on the matching pin. A prescaled tick input (`cntEn`) paces counting in the timed modes. A simple register port lets a host write and read the counter, both companions and a 9-bit control word. The counter and companions have no reset and must be written before use.

Top module: `dualreg_timer`

## Requirements
- R1: After reset the control word reads 0, `irq` is 0, `pinAOe` is 0 and `pinAOut` is 0.
- R2: A write to address 0, 1 or 2 loads the counter, register A or register B, and `rdData` shows the same address combinationally. Address 3 is the control word, using bits 8:0 only. Bits 15:9 of address 3 read as 0. In mode code 001 the counter holds.
- R3: Control layout: bit 0 run, bits 3:1 mode, bit 4 flag A, bit 5 enable A, bit 6 flag B, bit 7 enable B, bit 8 event edge. In mode 100 with run=1, each cycle with `cntEn`=1 decrements a nonzero counter. At zero the counter instead reloads, alternating between A and B with A first after run goes 0 to 1. Each reload toggles `pinAOut`, and `pinAOe` is 1.
- R4: Mode 101 reloads exactly as mode 100, but `pinAOe` is 0 and `pinAOut` never changes outside mode 100.
- R5: In the waveform modes flag A is set by each reload from A and by no reload from B.
- R6: With run=0 in the waveform modes or in the event mode (000), the counter holds whatever `cntEn` or pin A do.
- R7: In mode 000 with run=1, the counter ignores `cntEn` and decrements on a pin A edge: rising when bit 8 is 0, falling when it is 1. The edge takes effect two clocks after the pin changes. An edge at zero reloads from A and sets flag A.
- R8: In modes 110 and 111 the counter decrements on every `cntEn` cycle. It wraps from 0 to 0xFFFF, and that wrap sets bit 0, which is the underflow flag in these modes.
- R9: Mode 110 captures on rising edges and mode 111 on falling edges. A pin A edge copies the counter into A and sets flag A. A pin B edge copies it into B and sets flag B. An edge of the other polarity captures nothing.
- R10: Writing 0 to a flag bit clears it. A hardware set in the same cycle wins over the clearing write.
- R11: `irq` = (flag A and enable A) or (flag B and enable B) or (capture mode and bit 0 and enable A).
- R12: A host write to the counter overrides a reload or decrement in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| cntEn | input | 1 | Prescaled count tick |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address (0 counter, 1 A, 2 B, 3 control) |
| wrData | input | 16 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 16 | Read data, combinational |
| pinAIn | input | 1 | Pin A sensed level |
| pinBIn | input | 1 | Pin B sensed level |
| pinAOut | output | 1 | Pin A driven level |
| pinAOe | output | 1 | Pin A drive enable |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the following: decrement by one in the waveform mode, hold while stopped, the wrap to 0xFFFF with its underflow flag in capture mode, the pin A level staying still outside mode 100, and the interrupt equation. Other behaviours need the bench's scenarios, because they depend on history or on values the checker cannot see. These are the alternation between A and B and which of them comes first, the two-clock latency of pin edges, the edge polarity of event counting and capture, the values latched into A and B, and a flag set winning over a clearing write in the same cycle.

// File: rtl/dualreg_timer_pkg.sv
package dualreg_timer_pkg;
  localparam int ADDR_W = 2;
  localparam int CTRL_W = 9;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_A    = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_B    = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd3;

  // control word bit positions
  localparam int BIT_RUN   = 0;
  localparam int BIT_MODE  = 1;
  localparam int BIT_PNDA  = 4;
  localparam int BIT_ENA   = 5;
  localparam int BIT_PNDB  = 6;
  localparam int BIT_ENB   = 7;
  localparam int BIT_EVFAL = 8;

  typedef enum logic [2:0] {
    MODE_EVENT     = 3'b000,
    MODE_PWM_PIN   = 3'b100,
    MODE_PWM_QUIET = 3'b101,
    MODE_CAP_RISE  = 3'b110,
    MODE_CAP_FALL  = 3'b111
  } mode_e;

  typedef struct packed {
    logic decCnt;
    logic reloadA;
    logic reloadB;
    logic capA;
    logic capB;
  } dp_strobe_t;
endpackage

// File: rtl/dualreg_timer_edge.sv
module dualreg_timer_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pinIn,
  output logic rise,
  output logic fall
);
  logic syncQ;
  logic prevQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ <= 1'b0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= pinIn;
      prevQ <= syncQ;
    end
  end

  assign rise = syncQ & ~prevQ;
  assign fall = ~syncQ & prevQ;
endmodule

// File: rtl/dualreg_timer_dp.sv
module dualreg_timer_dp
  import dualreg_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [W-1:0]      wrData,
  input  dp_strobe_t        stb,
  output logic [W-1:0]      cntVal,
  output logic [W-1:0]      regAVal,
  output logic [W-1:0]      regBVal,
  output logic              cntZero
);
  logic [W-1:0] cntQ;
  logic [W-1:0] regAQ;
  logic [W-1:0] regBQ;

  // counter and companions power up undefined; the host loads them
  always_ff @(posedge clk) begin
    if (wrEn && wrAddr == ADDR_CNT)  cntQ <= wrData;
    else if (stb.reloadA)            cntQ <= regAQ;
    else if (stb.reloadB)            cntQ <= regBQ;
    else if (stb.decCnt)             cntQ <= cntQ - 1'b1;

    if (wrEn && wrAddr == ADDR_A)    regAQ <= wrData;
    else if (stb.capA)               regAQ <= cntQ;

    if (wrEn && wrAddr == ADDR_B)    regBQ <= wrData;
    else if (stb.capB)               regBQ <= cntQ;
  end

  assign cntVal  = cntQ;
  assign regAVal = regAQ;
  assign regBVal = regBQ;
  assign cntZero = (cntQ == '0);
endmodule

// File: rtl/dualreg_timer_ctrl.sv
module dualreg_timer_ctrl
  import dualreg_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cntEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              pinAIn,
  input  logic              pinBIn,
  input  logic              cntZero,
  output dp_strobe_t        stb,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic              pinAOut,
  output logic              pinAOe,
  output logic              irq
);
  localparam int NPIN = 2;

  logic       run, pendA, enA, pendB, enB, evFall;
  logic [2:0] mode;
  logic       phaseB;
  logic       pinQ;

  logic [NPIN-1:0] pinVec;
  logic [NPIN-1:0] pinRise;
  logic [NPIN-1:0] pinFall;
  logic [NPIN-1:0] capSel;

  assign pinVec = {pinBIn, pinAIn};

  for (genvar i = 0; i < NPIN; i++) begin : g_edge
    dualreg_timer_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pinIn (pinVec[i]),
      .rise  (pinRise[i]),
      .fall  (pinFall[i])
    );
    assign capSel[i] = mode[0] ? pinFall[i] : pinRise[i];
  end

  logic isPwm, isCap, isEvt, tick, underflow, wrCtrl;

  assign isPwm  = (mode[2:1] == 2'b10);
  assign isCap  = (mode[2:1] == 2'b11);
  assign isEvt  = (mode == MODE_EVENT);
  assign wrCtrl = wrEn && (wrAddr == ADDR_CTRL);

  always_comb begin
    tick = 1'b0;
    if (isPwm)      tick = run & cntEn;
    else if (isCap) tick = cntEn;
    else if (isEvt) tick = run & (evFall ? pinFall[0] : pinRise[0]);
  end

  assign underflow = tick & cntZero;

  always_comb begin
    stb.decCnt  = isCap ? tick : (tick & ~cntZero);
    stb.reloadA = underflow & (isEvt | (isPwm & ~phaseB));
    stb.reloadB = underflow & isPwm & phaseB;
    stb.capA    = isCap & capSel[0];
    stb.capB    = isCap & capSel[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      mode   <= 3'b000;
      pendA  <= 1'b0;
      enA    <= 1'b0;
      pendB  <= 1'b0;
      enB    <= 1'b0;
      evFall <= 1'b0;
      phaseB <= 1'b0;
      pinQ   <= 1'b0;
    end else begin
      if (wrCtrl) begin
        mode   <= wrData[BIT_MODE +: 3];
        enA    <= wrData[BIT_ENA];
        enB    <= wrData[BIT_ENB];
        evFall <= wrData[BIT_EVFAL];
      end
      // hardware sets win over a clearing write
      run   <= (wrCtrl ? wrData[BIT_RUN]  : run)   | (isCap & underflow);
      pendA <= (wrCtrl ? wrData[BIT_PNDA] : pendA) | stb.reloadA | stb.capA;
      pendB <= (wrCtrl ? wrData[BIT_PNDB] : pendB) | stb.capB;

      if (wrCtrl && wrData[BIT_RUN] && !run) phaseB <= 1'b0;
      else if (isPwm && underflow)           phaseB <= ~phaseB;

      if (mode == MODE_PWM_PIN && underflow) pinQ <= ~pinQ;
    end
  end

  assign ctrlWord = {evFall, enB, pendB, enA, pendA, mode, run};
  assign pinAOut  = pinQ;
  assign pinAOe   = (mode == MODE_PWM_PIN);
  assign irq      = (pendA & enA) | (pendB & enB) | (isCap & run & enA);
endmodule

// File: rtl/dualreg_timer.sv
module dualreg_timer
  import dualreg_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cntEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  input  logic              pinAIn,
  input  logic              pinBIn,
  output logic              pinAOut,
  output logic              pinAOe,
  output logic              irq
);
  localparam int PAD_W = CNT_W - CTRL_W;

  dp_strobe_t        stb;
  logic              cntZero;
  logic [CTRL_W-1:0] ctrlWord;
  logic [CNT_W-1:0]  cntVal;
  logic [CNT_W-1:0]  regAVal;
  logic [CNT_W-1:0]  regBVal;

  dualreg_timer_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cntEn    (cntEn),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData[CTRL_W-1:0]),
    .pinAIn   (pinAIn),
    .pinBIn   (pinBIn),
    .cntZero  (cntZero),
    .stb      (stb),
    .ctrlWord (ctrlWord),
    .pinAOut  (pinAOut),
    .pinAOe   (pinAOe),
    .irq      (irq)
  );

  dualreg_timer_dp #(.W(CNT_W)) u_dp (
    .clk     (clk),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .stb     (stb),
    .cntVal  (cntVal),
    .regAVal (regAVal),
    .regBVal (regBVal),
    .cntZero (cntZero)
  );

  always_comb begin
    case (rdAddr)
      ADDR_CNT: rdData = cntVal;
      ADDR_A:   rdData = regAVal;
      ADDR_B:   rdData = regBVal;
      default:  rdData = {{PAD_W{1'b0}}, ctrlWord};
    endcase
  end
endmodule

// File: rtl/dualreg_timer_chk.sv
module dualreg_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cntEn,
  input logic         wrEn,
  input logic [8:0]   ctrlWord,
  input logic [W-1:0] cntVal,
  input logic         pinAOut,
  input logic         pinAOe,
  input logic         irq
);
  p_reset_clear_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (ctrlWord == '0 && !irq && !pinAOe && !pinAOut));

  p_pwm_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrEn && ctrlWord[3:2] == 2'b10 && ctrlWord[0] && cntEn && cntVal != '0)
    |=> (cntVal == $past(cntVal) - 1'b1));

  p_pin_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlWord[3:1] != 3'b100) |=> $stable(pinAOut));

  p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrEn && !ctrlWord[0] && (ctrlWord[3:2] == 2'b10 || ctrlWord[3:1] == 3'b000))
    |=> $stable(cntVal));

  p_cap_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrEn && ctrlWord[3:2] == 2'b11 && cntEn && cntVal == '0)
    |=> (cntVal == {W{1'b1}} && ctrlWord[0]));

  p_irq_eqn_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (irq == ((ctrlWord[4] & ctrlWord[5]) | (ctrlWord[6] & ctrlWord[7]) |
                      ((ctrlWord[3:2] == 2'b11) & ctrlWord[0] & ctrlWord[5]))));
endmodule

bind dualreg_timer dualreg_timer_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cntEn    (cntEn),
  .wrEn     (wrEn),
  .ctrlWord (ctrlWord),
  .cntVal   (cntVal),
  .pinAOut  (pinAOut),
  .pinAOe   (pinAOe),
  .irq      (irq)
);

// File: tb/dualreg_timer_tb_top.sv
module dualreg_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cntEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic [1:0]  rdAddr = 2'd0;
  logic [15:0] rdData;
  logic        pinAIn = 1'b0;
  logic        pinBIn = 1'b0;
  logic        pinAOut, pinAOe, irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dualreg_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cntEn(cntEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .pinAIn(pinAIn),
    .pinBIn(pinBIn), .pinAOut(pinAOut), .pinAOe(pinAOe), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ctl(input bit run, input logic [2:0] mode, input bit pA,
                                      input bit eA, input bit pB, input bit eB, input bit evF);
    return {7'd0, evF, eB, pB, eA, pA, mode, run};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    rdAddr = a; #1; v = rdData;
  endtask

  task automatic tickEn();
    @(negedge clk); cntEn = 1'b1;
    @(negedge clk); cntEn = 1'b0;
  endtask

  task automatic setPin(input bit whichB, input bit val);
    @(negedge clk);
    if (whichB) pinBIn = val; else pinAIn = val;
    repeat (3) @(negedge clk);
  endtask

  task automatic runPwm(input logic [2:0] mode, input int steps);
    logic [15:0] va, vb, vc, v;
    bit phase, expPin, expPndA;
    va = 16'($urandom_range(0, 4));
    vb = 16'($urandom_range(0, 4));
    vc = 16'($urandom_range(0, 3));
    wr(2'd1, va); wr(2'd2, vb);
    wr(2'd3, ctl(0, mode, 0, 0, 0, 0, 0));
    wr(2'd0, vc);
    wr(2'd3, ctl(1, mode, 0, 0, 0, 0, 0));
    phase = 0; expPin = pinAOut; expPndA = 0;
    check(mode == 3'b100 ? "R3 drive enable" : "R4 drive enable", {15'd0, pinAOe},
          {15'd0, mode == 3'b100});
    for (int i = 0; i < steps; i++) begin
      bit en;
      en = ($urandom_range(0, 3) != 0);
      if (en) tickEn(); else @(negedge clk);
      if (en) begin
        if (vc == 0) begin
          vc = phase ? vb : va;
          if (!phase) expPndA = 1;
          phase = ~phase;
          if (mode == 3'b100) expPin = ~expPin;
        end else vc = vc - 1;
      end
      rd(2'd0, v);
      check("R3 counter/reload", v, vc);
      check(mode == 3'b100 ? "R3 pin toggle" : "R4 pin quiet", {15'd0, pinAOut}, {15'd0, expPin});
      rd(2'd3, v);
      check("R5 flag A on reload from A only", {15'd0, v[4]}, {15'd0, expPndA});
      if (expPndA) begin
        wr(2'd3, ctl(1, mode, 0, 0, 0, 0, 0));
        expPndA = 0;
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, cv, w;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd3, v);
    check("R1 control", v, 16'd0);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 oe", {15'd0, pinAOe}, 16'd0);
    check("R1 pin", {15'd0, pinAOut}, 16'd0);

    // R2 register access in idle mode 001
    wr(2'd3, 16'hFFA2);
    rd(2'd3, v);
    check("R2 control readback", v, 16'h01A2);
    wr(2'd3, ctl(0, 3'b001, 0, 0, 0, 0, 0));
    for (int i = 0; i < 6; i++) begin
      logic [1:0] a;
      a = 2'($urandom_range(0, 2));
      cv = 16'($urandom);
      wr(a, cv);
      tickEn();
      rd(a, v);
      check("R2 write/read", v, cv);
    end

    // R3/R5 waveform with pin, R4 without
    runPwm(3'b100, 30);
    runPwm(3'b101, 20);

    // R6 stopped
    wr(2'd3, ctl(0, 3'b100, 0, 0, 0, 0, 0));
    wr(2'd0, 16'd5);
    repeat (3) tickEn();
    rd(2'd0, v);
    check("R6 stopped hold", v, 16'd5);

    // R12 host write wins over reload
    wr(2'd1, 16'd4);
    wr(2'd0, 16'd0);
    wr(2'd3, ctl(1, 3'b100, 0, 0, 0, 0, 0));
    @(negedge clk); wrEn = 1'b1; wrAddr = 2'd0; wrData = 16'd9; cntEn = 1'b1;
    @(negedge clk); wrEn = 1'b0; cntEn = 1'b0;
    rd(2'd0, v);
    check("R12 write beats reload", v, 16'd9);

    // R7 event counting
    wr(2'd3, ctl(0, 3'b000, 0, 0, 0, 0, 0));
    wr(2'd1, 16'd3);
    wr(2'd0, 16'd1);
    setPin(0, 1); setPin(0, 0);
    rd(2'd0, v);
    check("R6 event stopped hold", v, 16'd1);
    wr(2'd3, ctl(1, 3'b000, 0, 0, 0, 0, 0));
    tickEn(); tickEn();
    rd(2'd0, v);
    check("R7 ignores cntEn", v, 16'd1);
    setPin(0, 1);
    rd(2'd0, v);
    check("R7 rising counts", v, 16'd0);
    setPin(0, 0);
    rd(2'd0, v);
    check("R7 falling ignored", v, 16'd0);
    setPin(0, 1);
    rd(2'd0, v);
    check("R7 reload from A", v, 16'd3);
    rd(2'd3, v);
    check("R7 flag A", {15'd0, v[4]}, 16'd1);
    wr(2'd3, ctl(1, 3'b000, 0, 0, 0, 0, 1));
    setPin(0, 0);
    setPin(0, 1);
    setPin(0, 0);
    rd(2'd0, v);
    check("R7 falling edge select", v, 16'd1);

    // R8 capture free run and wrap
    wr(2'd3, ctl(0, 3'b110, 0, 0, 0, 0, 0));
    wr(2'd0, 16'd1);
    tickEn();
    rd(2'd3, v);
    check("R8 no early underflow", {15'd0, v[0]}, 16'd0);
    tickEn();
    rd(2'd0, v);
    check("R8 wrap", v, 16'hFFFF);
    rd(2'd3, v);
    check("R8 underflow flag", {15'd0, v[0]}, 16'd1);
    check("R11 irq off without enable", {15'd0, irq}, 16'd0);
    wr(2'd3, ctl(1, 3'b110, 0, 1, 0, 0, 0));
    check("R11 irq from underflow", {15'd0, irq}, 16'd1);
    wr(2'd3, ctl(0, 3'b110, 0, 1, 0, 0, 0));
    rd(2'd3, v);
    check("R10 clear underflow", {15'd0, v[0]}, 16'd0);
    check("R11 irq dropped", {15'd0, irq}, 16'd0);

    // R9 capture, rising then falling
    cv = 16'($urandom);
    wr(2'd3, ctl(0, 3'b110, 0, 0, 0, 0, 0));
    wr(2'd0, cv);
    setPin(0, 1);
    rd(2'd1, v);
    check("R9 rising capture A", v, cv);
    rd(2'd3, v);
    check("R9 flag A", {15'd0, v[4]}, 16'd1);
    check("R9 flag B untouched", {15'd0, v[6]}, 16'd0);
    setPin(1, 1);
    rd(2'd2, v);
    check("R9 rising capture B", v, cv);
    rd(2'd3, v);
    check("R9 flag B", {15'd0, v[6]}, 16'd1);
    w = cv;
    cv = 16'($urandom);
    wr(2'd3, ctl(0, 3'b111, 0, 0, 1, 0, 0));
    wr(2'd0, cv);
    setPin(0, 0);
    rd(2'd1, v);
    check("R9 falling capture A", v, cv);
    rd(2'd2, v);
    check("R9 B kept", v, w);
    setPin(0, 1);
    wr(2'd0, 16'h1234);
    setPin(0, 1);
    rd(2'd1, v);
    check("R9 rising ignored in 111", v, cv);
    setPin(1, 0);
    rd(2'd2, v);
    check("R9 falling capture B", v, 16'h1234);

    // R10 flag B clear, and set beating clear
    wr(2'd3, ctl(0, 3'b111, 0, 0, 0, 0, 0));
    rd(2'd3, v);
    check("R10 clear flag B", {15'd0, v[6]}, 16'd0);
    wr(2'd0, 16'd0);
    @(negedge clk); wrEn = 1'b1; wrAddr = 2'd3; wrData = ctl(0, 3'b110, 0, 0, 0, 0, 0); cntEn = 1'b1;
    @(negedge clk); wrEn = 1'b0; cntEn = 1'b0;
    rd(2'd3, v);
    check("R10 set wins over clear", {15'd0, v[0]}, 16'd1);

    // R11 flag B path
    wr(2'd3, ctl(0, 3'b001, 0, 0, 1, 0, 0));
    check("R11 flag B masked", {15'd0, irq}, 16'd0);
    wr(2'd3, ctl(0, 3'b001, 0, 0, 1, 1, 0));
    check("R11 flag B enabled", {15'd0, irq}, 16'd1);
    wr(2'd3, ctl(0, 3'b001, 1, 0, 0, 1, 0));
    check("R11 flag A masked", {15'd0, irq}, 16'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule